// File: doc/BRIEF.md
# Indexed Interrupt Redirection Table

This block routes a set of external interrupt pins to a single delivery port. Each pin owns one configuration entry. The entry holds the vector code to deliver, the trigger mode, the input polarity and a mask bit. Software never addresses the entries directly. It first writes an entry number into a select register, and then reads or writes that entry through a data window.

Each clock, the block watches its pins. An unmasked pin that fires becomes a request. When the delivery port is empty, the lowest-numbered requesting pin is taken, and its vector is held on a valid/ready interface until the consumer accepts it.

Edge-triggered pins deliver once for each transition into the active state. A level-triggered pin delivers while it is active and its in-service flag is clear. It then stays quiet until an end-of-interrupt with its vector arrives on a separate input.

The entry for pin n sits at table index 0x10 + 2n. Odd indices, indices below 0x10 and indices past the last pin hold nothing.

Top module: `pin_vector_router`

## Requirements
- R1: During and after reset, no delivery is presented, and every entry reads 0x00010000 (only the mask bit is set).
- R2: Register offset 0x00 is the select register, which is written and read back in bits 7:0. Offset 0x10 is the data window onto the entry chosen by the select register. The entry of pin n is at index 0x10 + 2n, so pin 8 is at 0x20.
- R3: A delivery carries bits 7:0 of the firing pin's entry as its vector.
- R4: While entry bit 16 (mask) is set, the pin produces no delivery, and edges seen while masked are discarded.
- R5: With bit 15 clear (edge mode), a pin delivers exactly once per inactive-to-active transition, however long it stays active.
- R6: With bit 15 set (level mode), a pin delivers when active and bit 14 (in-service) is clear. Delivery sets bit 14, and no further delivery occurs until an end-of-interrupt input carries the entry's vector.
- R7: Bit 13 set makes a pin active when low; both modes honour it.
- R8: Window accesses to an odd index, to an index below 0x10, or to an index beyond the last pin read as zero and change nothing. Any other register offset reads zero.
- R9: When several pins request at once, the lowest-numbered pin is delivered first.
- R10: Once valid is raised, valid and vector stay unchanged until ready is seen high at a clock edge.
- R11: Bit 12 reads 1 while the pin has a request waiting. Bits 12 and 14 are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset (0x00 select, 0x10 window) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_in | input | NUM_PINS | External interrupt pins, synchronous to clk |
| dlv_valid | output | 1 | Delivery vector valid |
| dlv_vector | output | 8 | Vector being delivered |
| dlv_ready | input | 1 | Consumer accepts the delivery |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt |

## Verification
The pins are driven in four patterns, and each one separates a different behaviour:
- A long active pulse on an edge pin checks that one transition gives exactly one delivery.
- A held level pin with and without an end-of-interrupt shows whether the in-service flag gates re-delivery.
- An active-low pin at rest shows whether polarity is applied before edge detection.
- Two pins raised in the same cycle while ready is low show the priority order, the stability of the held vector and the pending status of the loser.

A behavioural model predicts valid and vector on every cycle, so a delivery that comes one cycle early or late is caught along with a wrong vector.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
    localparam int VEC_W     = 8;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] OFF_SELECT = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_WINDOW = 8'h10;
    localparam logic [7:0]        TBL_BASE   = 8'h10;

    localparam int B_STATUS = 12;
    localparam int B_POL    = 13;
    localparam int B_INSVC  = 14;
    localparam int B_LEVEL  = 15;
    localparam int B_MASK   = 16;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        logic             polarity;
        logic             level;
        logic             mask;
    } entry_cfg_t;

    typedef struct packed {
        entry_cfg_t cfg;
        logic       prev_active;
        logic       edge_pend;
        logic       insvc;
    } pin_state_t;

    function automatic logic [DATA_W-1:0] pack_entry(
        input entry_cfg_t c, input logic status, input logic insvc);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[7:0]      = c.vector;
        w[B_STATUS] = status;
        w[B_POL]    = c.polarity;
        w[B_INSVC]  = insvc;
        w[B_LEVEL]  = c.level;
        w[B_MASK]   = c.mask;
        return w;
    endfunction
endpackage

// File: rtl/pvr_pin_ctrl.sv
module pvr_pin_ctrl
    import pvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              irq_raw,
    input  logic              grant,
    input  logic              eoi_valid,
    input  logic [VEC_W-1:0]  eoi_vector,
    output logic              req,
    output logic [DATA_W-1:0] entry_word,
    output logic [VEC_W-1:0]  vector_o,
    output logic              mask_o,
    output logic              insvc_o
);
    pin_state_t st_d, st_q;
    logic       active;

    always_comb begin
        active = irq_raw ^ st_q.cfg.polarity;
        req    = !st_q.cfg.mask &&
                 (st_q.cfg.level ? (active && !st_q.insvc) : st_q.edge_pend);

        st_d             = st_q;
        st_d.prev_active = active;

        if (grant)
            st_d.edge_pend = 1'b0;
        if (active && !st_q.prev_active)
            st_d.edge_pend = 1'b1;
        if (st_q.cfg.mask || st_q.cfg.level)
            st_d.edge_pend = 1'b0;

        if (eoi_valid && (eoi_vector == st_q.cfg.vector))
            st_d.insvc = 1'b0;
        if (grant && st_q.cfg.level)
            st_d.insvc = 1'b1;

        if (cfg_we) begin
            st_d.cfg.vector   = cfg_wdata[7:0];
            st_d.cfg.polarity = cfg_wdata[B_POL];
            st_d.cfg.level    = cfg_wdata[B_LEVEL];
            st_d.cfg.mask     = cfg_wdata[B_MASK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cfg.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign entry_word = pack_entry(st_q.cfg, req, st_q.insvc);
    assign vector_o   = st_q.cfg.vector;
    assign mask_o     = st_q.cfg.mask;
    assign insvc_o    = st_q.insvc;
endmodule

// File: rtl/pvr_first_set.sv
module pvr_first_set #(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (any && (idx == IDX_W'(i)))
                onehot[i] = 1'b1;
        end
    end
endmodule

// File: rtl/pin_vector_router.sv
module pin_vector_router
    import pvr_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] irq_in,
    output logic                dlv_valid,
    output logic [7:0]          dlv_vector,
    input  logic                dlv_ready,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector
);
    localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    typedef struct packed {
        logic [7:0]       select;
        logic             out_valid;
        logic [VEC_W-1:0] out_vector;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_PINS-1:0] req_v;
    logic [NUM_PINS-1:0] grant_v;
    logic [NUM_PINS-1:0] onehot_v;
    logic [NUM_PINS-1:0] mask_v;
    logic [NUM_PINS-1:0] rirr_v;
    logic [NUM_PINS-1:0] cfg_we_v;
    logic [DATA_W-1:0]   word_a [NUM_PINS];
    logic [VEC_W-1:0]    vec_a  [NUM_PINS];
    logic                any_req;
    logic [PIN_IDX_W-1:0] win_idx;
    logic                load;
    logic [7:0]          sel_off;
    logic                in_table;
    logic [VEC_W-1:0]    win_vec;

    // Window decode: index -> pin number
    always_comb begin
        sel_off  = st_q.select - TBL_BASE;
        in_table = (st_q.select >= TBL_BASE) && !st_q.select[0] &&
                   (int'(sel_off[7:1]) < NUM_PINS);
    end

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            assign cfg_we_v[p] = reg_we && (reg_addr == OFF_WINDOW) && in_table &&
                                 (int'(sel_off[7:1]) == p);
            pvr_pin_ctrl u_pin (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg_we     (cfg_we_v[p]),
                .cfg_wdata  (reg_wdata),
                .irq_raw    (irq_in[p]),
                .grant      (grant_v[p]),
                .eoi_valid  (eoi_valid),
                .eoi_vector (eoi_vector),
                .req        (req_v[p]),
                .entry_word (word_a[p]),
                .vector_o   (vec_a[p]),
                .mask_o     (mask_v[p]),
                .insvc_o    (rirr_v[p])
            );
        end
    endgenerate

    pvr_first_set #(.N(NUM_PINS), .IDX_W(PIN_IDX_W)) u_arb (
        .req    (req_v),
        .any    (any_req),
        .idx    (win_idx),
        .onehot (onehot_v)
    );

    assign load    = !st_q.out_valid && any_req;
    assign grant_v = load ? onehot_v : '0;

    always_comb begin
        win_vec = '0;
        for (int p = 0; p < NUM_PINS; p++)
            if (win_idx == PIN_IDX_W'(p))
                win_vec = vec_a[p];
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_SELECT) begin
            reg_rdata[7:0] = st_q.select;
        end else if ((reg_addr == OFF_WINDOW) && in_table) begin
            for (int p = 0; p < NUM_PINS; p++)
                if (int'(sel_off[7:1]) == p)
                    reg_rdata = word_a[p];
        end
    end

    always_comb begin
        st_d = st_q;
        if (reg_we && (reg_addr == OFF_SELECT))
            st_d.select = reg_wdata[7:0];
        if (st_q.out_valid && dlv_ready)
            st_d.out_valid = 1'b0;
        if (load) begin
            st_d.out_valid  = 1'b1;
            st_d.out_vector = win_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dlv_valid  = st_q.out_valid;
    assign dlv_vector = st_q.out_vector;
endmodule

// File: rtl/pvr_checker.sv
module pvr_checker #(
    parameter int N = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dlv_valid,
    input logic         dlv_ready,
    input logic [7:0]   dlv_vector,
    input logic [N-1:0] grant,
    input logic [N-1:0] mask_v,
    input logic [N-1:0] rirr_v
);
    p_idle_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> !dlv_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_vector)));

    p_load_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> !dlv_valid);

    p_no_masked_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((grant & mask_v) == '0));

    p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_insvc_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rirr_v & ~$past(rirr_v))) |-> $past(|grant));
endmodule

bind pin_vector_router pvr_checker #(.N(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dlv_valid  (dlv_valid),
    .dlv_ready  (dlv_ready),
    .dlv_vector (dlv_vector),
    .grant      (grant_v),
    .mask_v     (mask_v),
    .rirr_v     (rirr_v)
);

// File: tb/pin_vector_router_test.sv
module pin_vector_router_test;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] irq = '0;
    logic        dlv_valid;
    logic [7:0]  dlv_vector;
    logic        rdy = 1'b1;
    logic        eoi = 1'b0;
    logic [7:0]  eoi_vec = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_vector_router #(.NUM_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_in(irq),
        .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_ready(rdy),
        .eoi_valid(eoi), .eoi_vector(eoi_vec)
    );

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_vec  [N];
    bit       m_pol  [N];
    bit       m_lvl  [N];
    bit       m_mask [N];
    bit       m_prev [N];
    bit       m_pend [N];
    bit       m_busy [N];
    bit       m_act  [N];
    int       m_sel;
    int       m_wp;
    int       m_idx;
    bit       m_val;
    bit       m_old;
    int       m_out;
    int       hs [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) begin
                m_vec[p] = 0; m_pol[p] = 0; m_lvl[p] = 0; m_mask[p] = 1;
                m_prev[p] = 0; m_pend[p] = 0; m_busy[p] = 0;
            end
            m_idx = 0; m_val = 0; m_out = 0;
            for (int v = 0; v < 256; v++) hs[v] = 0;
        end else begin
            m_sel = -1;
            for (int p = 0; p < N; p++) begin
                m_act[p] = irq[p] ^ m_pol[p];
                if (m_sel < 0 && !m_mask[p] &&
                    (m_lvl[p] ? (m_act[p] && !m_busy[p]) : m_pend[p]))
                    m_sel = p;
            end
            m_wp = -1;
            if (we && addr == 8'h10 && m_idx >= 16 && (m_idx % 2) == 0 &&
                (m_idx - 16) / 2 < N)
                m_wp = (m_idx - 16) / 2;
            m_old = m_val;
            if (m_old && rdy) begin
                hs[m_out] = hs[m_out] + 1;
                m_val = 0;
            end
            if (!m_old && m_sel >= 0) begin
                m_val = 1;
                m_out = m_vec[m_sel];
            end
            for (int p = 0; p < N; p++) begin
                if (!m_old && m_sel == p) m_pend[p] = 0;
                if (m_act[p] && !m_prev[p]) m_pend[p] = 1;
                if (m_mask[p] || m_lvl[p]) m_pend[p] = 0;
                if (eoi && eoi_vec == m_vec[p]) m_busy[p] = 0;
                if (!m_old && m_sel == p && m_lvl[p]) m_busy[p] = 1;
                m_prev[p] = m_act[p];
                if (m_wp == p) begin
                    m_vec[p]  = wdata[7:0];
                    m_pol[p]  = wdata[13];
                    m_lvl[p]  = wdata[15];
                    m_mask[p] = wdata[16];
                end
            end
            if (we && addr == 8'h00) m_idx = wdata[7:0];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of the delivery port (R3, R10)
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            check(dlv_valid == m_val, "R10 valid per cycle", 32'(dlv_valid), 32'(m_val));
            if (m_val)
                check(dlv_vector == 8'(m_out), "R3 vector per cycle",
                      32'(dlv_vector), 32'(m_out));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #2;
        check(rdata === exp, tag, rdata, exp);
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi = 1'b1; eoi_vec = v;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle(3);
        check(dlv_valid == 1'b0, "R1 no delivery in reset", 32'(dlv_valid), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R1 / R2: reset entries, select register, window mapping
        wr(8'h00, 32'h20);
        rd(8'h00, 32'h20, "R2 select readback");
        rd(8'h10, 32'h0001_0000, "R1 reset entry pin 8");
        wr(8'h10, 32'h0000_00D1);
        rd(8'h10, 32'h0000_00D1, "R2 window readback");

        // R5: one delivery per rising transition
        @(negedge clk); irq[8] = 1'b1;
        idle(6);
        check(hs[8'hD1] == 1, "R5 first edge", 32'(hs[8'hD1]), 32'd1);
        idle(8);
        check(hs[8'hD1] == 1, "R5 held high no repeat", 32'(hs[8'hD1]), 32'd1);
        @(negedge clk); irq[8] = 1'b0;
        idle(2);
        @(negedge clk); irq[8] = 1'b1;
        idle(6);
        check(hs[8'hD1] == 2, "R5 second edge", 32'(hs[8'hD1]), 32'd2);

        // R4: masked pin silent
        @(negedge clk); irq[8] = 1'b0;
        wr(8'h10, 32'h0001_00D1);
        @(negedge clk); irq[8] = 1'b1;
        idle(3);
        @(negedge clk); irq[8] = 1'b0;
        idle(6);
        check(hs[8'hD1] == 2, "R4 masked edge dropped", 32'(hs[8'hD1]), 32'd2);
        check(dlv_valid == 1'b0, "R4 no pending delivery", 32'(dlv_valid), 32'h0);

        // R6: level pin 3 and end-of-interrupt
        wr(8'h00, 32'h16);
        wr(8'h10, 32'h0000_8045);
        @(negedge clk); irq[3] = 1'b1;
        idle(6);
        check(hs[8'h45] == 1, "R6 level first delivery", 32'(hs[8'h45]), 32'd1);
        rd(8'h10, 32'h0000_C045, "R6 in-service bit set");
        idle(8);
        check(hs[8'h45] == 1, "R6 no repeat before EOI", 32'(hs[8'h45]), 32'd1);
        send_eoi(8'h33);
        idle(5);
        check(hs[8'h45] == 1, "R6 EOI other vector ignored", 32'(hs[8'h45]), 32'd1);
        send_eoi(8'h45);
        idle(5);
        check(hs[8'h45] == 2, "R6 redelivery after EOI", 32'(hs[8'h45]), 32'd2);
        @(negedge clk); irq[3] = 1'b0;
        send_eoi(8'h45);
        idle(4);
        rd(8'h10, 32'h0000_8045, "R6 in-service cleared");
        check(hs[8'h45] == 2, "R6 inactive level silent", 32'(hs[8'h45]), 32'd2);

        // R7: active-low edge pin 5
        wr(8'h00, 32'h1A);
        wr(8'h10, 32'h0000_2077);
        idle(6);
        check(hs[8'h77] == 1, "R7 low pin is active", 32'(hs[8'h77]), 32'd1);
        @(negedge clk); irq[5] = 1'b1;
        idle(4);
        check(hs[8'h77] == 1, "R7 rising is inactive", 32'(hs[8'h77]), 32'd1);
        @(negedge clk); irq[5] = 1'b0;
        idle(6);
        check(hs[8'h77] == 2, "R7 falling delivers", 32'(hs[8'h77]), 32'd2);

        // R8: holes in the table
        wr(8'h00, 32'h11);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R8 odd index reads zero");
        wr(8'h00, 32'h0F);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R8 low index reads zero");
        wr(8'h00, 32'h40);
        wr(8'h10, 32'h0000_00FF);
        rd(8'h10, 32'h0, "R8 past table reads zero");
        wr(8'h00, 32'h3E);
        rd(8'h10, 32'h0001_0000, "R8 last pin untouched");
        wr(8'h00, 32'h1E);
        rd(8'h10, 32'h0001_0000, "R8 pin 7 untouched");
        rd(8'h04, 32'h0, "R8 unused offset");
        check(hs[8'hFF] == 0, "R8 no stray delivery", 32'(hs[8'hFF]), 32'd0);

        // R9 / R10 / R11: simultaneous requests, ready held low
        @(negedge clk); rdy = 1'b0;
        wr(8'h00, 32'h14);
        wr(8'h10, 32'h0000_0022);
        wr(8'h00, 32'h24);
        wr(8'h10, 32'h0000_002A);
        @(negedge clk); irq[2] = 1'b1; irq[10] = 1'b1;
        idle(5);
        check(dlv_valid == 1'b1, "R9 delivery present", 32'(dlv_valid), 32'h1);
        check(dlv_vector == 8'h22, "R9 lowest pin first", 32'(dlv_vector), 32'h22);
        rd(8'h10, 32'h0000_102A, "R11 pending status bit");
        idle(6);
        check(dlv_vector == 8'h22, "R10 held while not ready", 32'(dlv_vector), 32'h22);
        @(negedge clk); rdy = 1'b1;
        idle(5);
        check(hs[8'h22] == 1, "R9 winner accepted", 32'(hs[8'h22]), 32'd1);
        check(hs[8'h2A] == 1, "R9 loser follows", 32'(hs[8'h2A]), 32'd1);
        @(negedge clk); irq[2] = 1'b0; irq[10] = 1'b0;

        // R11: read-only bits ignore writes
        wr(8'h00, 32'h14);
        wr(8'h10, 32'h0000_5022);
        rd(8'h10, 32'h0000_0022, "R11 status and in-service read-only");
        idle(6);
        check(hs[8'h22] == 1, "R11 write causes no delivery", 32'(hs[8'h22]), 32'd1);

        idle(3);
        finish_run();
    end
endmodule